// File: doc/BRIEF.md
# Privilege and Banked Stack-Pointer Controller

This block keeps track of where the processor is executing and at what privilege. It follows the execution mode, which is either Thread or Handler. It holds a two-bit CONTROL register and two independent stack pointers: a main pointer and a process pointer. It also turns push and pop requests into word accesses on a simple memory port, using whichever pointer is active at the time.

Exception entry and supervisor-call requests move the block into Handler mode, and an exception return moves it back to Thread mode. In Handler mode, execution is always privileged and the main stack is always used. In Thread mode, the CONTROL bits choose both the privilege level and the stack. CONTROL accepts a write only when the requester says it is privileged. The stacks are full descending: a push stores at `sp-4` and moves the pointer there, and a pop reads at `sp` and then adds 4.

Top module: `priv_sp_ctrl`

## Requirements
- R1: After reset the block is in Thread mode (`handler_mode_o`=0), CONTROL reads 0, the main pointer holds `sp_init_i` with bits [1:0] cleared, and the process pointer holds 0.
- R2: A cycle with `exc_entry_i` or `svc_req_i` high puts the block in Handler mode from the next cycle. A cycle with `exc_return_i` high and neither entry input high puts it in Thread mode from the next cycle. If entry and return come together, entry wins.
- R3: In Handler mode `privileged_o` is 1 whatever CONTROL holds.
- R4: In Thread mode `privileged_o` equals the inverse of CONTROL bit 0 (bit 0 = 1 means unprivileged).
- R5: A CONTROL write (`ctrl_we_i`) updates `ctrl_o` on the next cycle only when `ctrl_req_priv_i` is 1. When it is 0, CONTROL is left unchanged.
- R6: `active_sp_o` is the main pointer in Handler mode. In Thread mode it is the process pointer when CONTROL bit 1 is 1, and the main pointer otherwise.
- R7: During a push, `mem_we_o`=1, `mem_addr_o`=`active_sp_o`-4 and `mem_wdata_o`=`push_data_i` in the same cycle. The selected pointer takes the value `active_sp_o`-4 at the clock edge.
- R8: During a pop without a push, `mem_re_o`=1, `mem_addr_o`=`active_sp_o` and `pop_data_o`=`mem_rdata_i`. The selected pointer then increases by 4.
- R9: When push and pop are requested in the same cycle, the push is performed and the pop is ignored (`mem_re_o`=0, no increment).
- R10: Both pointers, and therefore `active_sp_o` and `mem_addr_o`, always have bits [1:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_init_i | input | AW | Reset value for the main pointer |
| exc_entry_i | input | 1 | Exception entry strobe |
| svc_req_i | input | 1 | Supervisor-call request, treated as entry |
| exc_return_i | input | 1 | Exception return strobe |
| ctrl_we_i | input | 1 | CONTROL write strobe |
| ctrl_wdata_i | input | 2 | CONTROL write data (bit0 unpriv, bit1 process stack) |
| ctrl_req_priv_i | input | 1 | Requester is privileged |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | DW | Word to push |
| mem_rdata_i | input | DW | Memory read data |
| handler_mode_o | output | 1 | 1 in Handler mode |
| privileged_o | output | 1 | Current execution is privileged |
| ctrl_o | output | 2 | CONTROL register contents |
| active_sp_o | output | AW | Currently selected stack pointer |
| mem_addr_o | output | AW | Stack access address |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_wdata_o | output | DW | Stack write data |
| pop_data_o | output | DW | Popped word |

## Verification
The hardest case to reach is a push or pop onto the process stack in Thread mode. Reaching it needs a privileged CONTROL write that sets the stack-select bit, while the block sits in Thread mode and no entry is pending. A stack access made just before an entry or return edge is also hard to reach, because it must still use the pointer of the old mode. The random stimulus mixes privileged and unprivileged CONTROL writes, entries, supervisor calls and returns at rates that keep both modes and both stacks in use. Directed steps cover a push onto the process pointer from zero, a push and pop together, and entry and return together.

// File: rtl/priv_sp_pkg.sv
package priv_sp_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  localparam int unsigned CTRL_W      = 2;
  localparam int unsigned CTRL_NPRIV  = 0;
  localparam int unsigned CTRL_SPSEL  = 1;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned ALIGN_BITS  = $clog2(WORD_BYTES);
endpackage

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_i,
  input  logic              return_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              req_priv_i,
  output mode_e             mode_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              priv_o,
  output logic              use_psp_o
);
  mode_e             mode_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_THREAD;
    else if (entry_i)  mode_q <= MODE_HANDLER;
    else if (return_i) mode_q <= MODE_THREAD;
  end

  // only privileged requesters may change CONTROL
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ctrl_q <= '0;
    else if (ctrl_we_i && req_priv_i)  ctrl_q <= ctrl_wdata_i;
  end

  always_comb begin
    mode_o    = mode_q;
    ctrl_o    = ctrl_q;
    priv_o    = (mode_q == MODE_HANDLER) || !ctrl_q[CTRL_NPRIV];
    use_psp_o = (mode_q == MODE_THREAD) && ctrl_q[CTRL_SPSEL];
  end
endmodule

// File: rtl/priv_sp_bank.sv
module priv_sp_bank
  import priv_sp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sp_init_i,
  input  logic          use_psp_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] active_sp_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          re_o
);
  localparam int unsigned NUM_SP = 2;
  localparam int unsigned UW     = AW - ALIGN_BITS;

  logic [UW-1:0] sp_q [NUM_SP];
  logic [UW-1:0] sel_sp, dec_sp, inc_sp;
  logic          sel_idx;
  logic          do_pop;

  assign sel_idx = use_psp_i;
  assign sel_sp  = sp_q[sel_idx];
  assign dec_sp  = sel_sp - UW'(1);
  assign inc_sp  = sel_sp + UW'(1);
  assign do_pop  = pop_i && !push_i;

  for (genvar b = 0; b < NUM_SP; b++) begin : g_sp
    logic [UW-1:0] rst_val;
    if (b == 0) begin : g_main
      assign rst_val = sp_init_i[AW-1:ALIGN_BITS];
    end else begin : g_proc
      assign rst_val = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                sp_q[b] <= rst_val;
      else if (push_i && (sel_idx == b[0]))       sp_q[b] <= dec_sp;
      else if (do_pop && (sel_idx == b[0]))       sp_q[b] <= inc_sp;
    end
  end

  // full descending: push writes below, pop reads at the pointer
  always_comb begin
    active_sp_o = {sel_sp, ALIGN_BITS'(0)};
    addr_o      = push_i ? {dec_sp, ALIGN_BITS'(0)} : {sel_sp, ALIGN_BITS'(0)};
    we_o        = push_i;
    re_o        = do_pop;
  end
endmodule

// File: rtl/priv_sp_ctrl.sv
module priv_sp_ctrl
  import priv_sp_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     sp_init_i,
  input  logic              exc_entry_i,
  input  logic              svc_req_i,
  input  logic              exc_return_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ctrl_req_priv_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              handler_mode_o,
  output logic              privileged_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [AW-1:0]     active_sp_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic [DW-1:0]     pop_data_o
);
  mode_e mode;
  logic  use_psp;

  priv_mode_ctrl u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .entry_i      (exc_entry_i | svc_req_i),
    .return_i     (exc_return_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .req_priv_i   (ctrl_req_priv_i),
    .mode_o       (mode),
    .ctrl_o       (ctrl_o),
    .priv_o       (privileged_o),
    .use_psp_o    (use_psp)
  );

  priv_sp_bank #(.AW(AW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sp_init_i   (sp_init_i),
    .use_psp_i   (use_psp),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .active_sp_o (active_sp_o),
    .addr_o      (mem_addr_o),
    .we_o        (mem_we_o),
    .re_o        (mem_re_o)
  );

  assign handler_mode_o = (mode == MODE_HANDLER);
  assign mem_wdata_o    = push_data_i;
  assign pop_data_o     = mem_rdata_i;
endmodule

// File: rtl/priv_sp_ctrl_chk.sv
module priv_sp_ctrl_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          exc_entry_i,
  input logic          svc_req_i,
  input logic          exc_return_i,
  input logic          ctrl_we_i,
  input logic          ctrl_req_priv_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          handler_mode_o,
  input logic          privileged_o,
  input logic [1:0]    ctrl_o,
  input logic [AW-1:0] active_sp_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_re_o
);
  logic quiet;
  assign quiet = !exc_entry_i && !svc_req_i && !exc_return_i && !ctrl_we_i;

  // R2
  entry_to_handler_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_entry_i || svc_req_i) |=> handler_mode_o);
  // R2
  return_to_thread_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_return_i && !exc_entry_i && !svc_req_i) |=> !handler_mode_o);
  // R3
  handler_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handler_mode_o |-> privileged_o);
  // R4
  thread_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !handler_mode_o |-> (privileged_o == !ctrl_o[0]));
  // R5
  ctrl_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_req_priv_i) |=> $stable(ctrl_o));
  // R7
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (mem_addr_o == active_sp_o - AW'(4)));
  // R7
  push_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && quiet) |=> (active_sp_o == $past(mem_addr_o)));
  // R8
  pop_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && quiet) |=> (active_sp_o == $past(active_sp_o) + AW'(4)));
  // R9
  push_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !mem_re_o);
  // R10
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_sp_o[1:0] == 2'b00) && (mem_addr_o[1:0] == 2'b00));
endmodule

bind priv_sp_ctrl priv_sp_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .exc_entry_i     (exc_entry_i),
  .svc_req_i       (svc_req_i),
  .exc_return_i    (exc_return_i),
  .ctrl_we_i       (ctrl_we_i),
  .ctrl_req_priv_i (ctrl_req_priv_i),
  .push_i          (push_i),
  .pop_i           (pop_i),
  .handler_mode_o  (handler_mode_o),
  .privileged_o    (privileged_o),
  .ctrl_o          (ctrl_o),
  .active_sp_o     (active_sp_o),
  .mem_addr_o      (mem_addr_o),
  .mem_re_o        (mem_re_o)
);

// File: tb/sim_priv_sp_ctrl.sv
module sim_priv_sp_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] sp_init = 32'h0000_0403;
  logic          entry = 0, svc = 0, ret = 0, we = 0, rpriv = 0, push = 0, pop = 0;
  logic [1:0]    wdata = '0;
  logic [DW-1:0] pdata = '0;
  logic [DW-1:0] rdata;
  logic          hm, pv, mwe, mre;
  logic [1:0]    ctrl;
  logic [AW-1:0] asp, maddr;
  logic [DW-1:0] mwdata, popd;

  logic [31:0] mem [256];
  int n_chk = 0, n_fail = 0;

  // bench model
  logic       m_hm;
  logic [1:0] m_ctrl;
  logic [31:0] m_msp, m_psp;

  always #5 clk = ~clk;

  assign rdata = mem[maddr[9:2]];

  priv_sp_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sp_init_i(sp_init),
    .exc_entry_i(entry), .svc_req_i(svc), .exc_return_i(ret),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .ctrl_req_priv_i(rpriv),
    .push_i(push), .pop_i(pop), .push_data_i(pdata), .mem_rdata_i(rdata),
    .handler_mode_o(hm), .privileged_o(pv), .ctrl_o(ctrl),
    .active_sp_o(asp), .mem_addr_o(maddr), .mem_we_o(mwe), .mem_re_o(mre),
    .mem_wdata_o(mwdata), .pop_data_o(popd)
  );

  function automatic logic exp_psp();
    return !m_hm && m_ctrl[1];
  endfunction
  function automatic logic [31:0] exp_sp();
    return exp_psp() ? m_psp : m_msp;
  endfunction
  function automatic logic exp_priv();
    return m_hm || !m_ctrl[0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R2 mode", 32'(hm), 32'(m_hm));
    chk("R3/R4 privilege", 32'(pv), 32'(exp_priv()));
    chk("R5 control", 32'(ctrl), 32'(m_ctrl));
    chk("R6 active sp", asp, exp_sp());
    chk("R10 align", 32'(asp[1:0]), 32'd0);
  endtask

  // drive at negedge, check comb outputs, then commit at posedge
  task automatic step(logic e, logic s, logic r, logic w, logic [1:0] wd,
                      logic rp, logic pu, logic po, logic [31:0] d);
    logic [31:0] sp;
    @(negedge clk);
    check_state();
    entry = e; svc = s; ret = r; we = w; wdata = wd; rpriv = rp;
    push = pu; pop = po; pdata = d;
    #1;
    sp = exp_sp();
    if (pu) begin
      chk("R7 push addr", maddr, sp - 32'd4);
      chk("R7 push we", 32'(mwe), 32'd1);
      chk("R7 push data", mwdata, d);
      chk("R9 pop ignored", 32'(mre), 32'd0);
    end else if (po) begin
      chk("R8 pop addr", maddr, sp);
      chk("R8 pop re", 32'(mre), 32'd1);
      chk("R8 pop data", popd, mem[sp[9:2]]);
    end else begin
      chk("R7 idle we", 32'(mwe), 32'd0);
    end
    @(posedge clk);
    if (pu) mem[(sp - 32'd4) >> 2 & 32'hff] = d;
    if (pu) begin
      if (exp_psp()) m_psp = sp - 32'd4; else m_msp = sp - 32'd4;
    end else if (po) begin
      if (exp_psp()) m_psp = sp + 32'd4; else m_msp = sp + 32'd4;
    end
    if (w && rp) m_ctrl = wd;
    if (e || s) m_hm = 1'b1;
    else if (r) m_hm = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 32'hdead_0000 | 32'(i);
    m_hm = 0; m_ctrl = 0; m_msp = 32'h400; m_psp = 0;
    #12;
    // R1 reset state, R10 init forced aligned
    chk("R1 mode", 32'(hm), 32'd0);
    chk("R1 ctrl", 32'(ctrl), 32'd0);
    chk("R1 msp", asp, 32'h400);
    chk("R1 priv", 32'(pv), 32'd1);
    rst_ni = 1'b1;
    // R5 unprivileged write ignored
    step(0,0,0,1,2'b11,0,0,0,0);
    step(0,0,0,0,2'b00,0,0,0,0);
    chk("R5 unpriv ignored", 32'(ctrl), 32'd0);
    // R5 privileged write -> thread unpriv on process stack (R4, R6)
    step(0,0,0,1,2'b11,1,0,0,0);
    // R7/R10 push onto process pointer from zero
    step(0,0,0,0,2'b00,0,1,0,32'h1111_2222);
    step(0,0,0,0,2'b00,0,0,0,0);
    chk("R7 psp wrap", asp, 32'hffff_fffc);
    // R2 svc enters handler; R6 msp in handler; push+pop R9
    step(0,1,0,0,2'b00,0,0,0,0);
    step(0,0,0,0,2'b00,0,1,1,32'h3333_4444);
    step(0,0,0,0,2'b00,0,0,1,0);
    // R2 entry and return together: entry wins
    step(1,0,1,0,2'b00,0,0,0,0);
    step(0,0,0,0,2'b00,0,0,0,0);
    chk("R2 entry wins", 32'(hm), 32'd1);
    // R2 return, then pop process stack
    step(0,0,1,0,2'b00,0,0,0,0);
    step(0,0,0,0,2'b00,0,0,1,0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 100;
      logic pu, po;
      pu = ($urandom % 3) == 0;
      po = ($urandom % 3) == 0;
      step(r < 6, r >= 6 && r < 9, r >= 9 && r < 18 || r == 5,
           (r % 7) == 0, 2'($urandom), ($urandom % 2) == 1,
           pu, po, $urandom);
    end
    @(negedge clk);
    check_state();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule